// File: doc/BRIEF.md
# Write-Update Snooping Line-State Controller

This block keeps the coherence state of every line of one write-back cache that takes part in a snooping protocol built on updates rather than invalidations. When the local processor writes a line that other caches also hold, the controller asks for a bus slot and broadcasts the written word, so the other copies stay valid and are patched in place. A line that the cache holds is always in one of four states: exclusive-clean, shared-clean, shared-owner (this cache owns dirty shared data and memory is stale) or dirty (the only copy, modified). A line that the cache does not hold is simply absent.

The processor side presents one operation at a time (read, write or eviction) on a line index and holds it until `cpu_done`. Hits that need no bus traffic finish in the same cycle. Misses, writes to shared lines and evictions of dirty lines raise a bus request and finish when the grant comes. On the snoop side the block watches the reads and word updates of other caches. It answers on the wired-OR shared line, asks for a flush when it owns dirty data, and strobes `snp_apply` when the snooped word is to be written into its copy. The data arrays, the arbiter and memory sit outside this block.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is absent and no request, flush, shared, done or write strobe is driven. The first read of any line raises a bus read.
- R2: A read of an absent line requests a bus read (bus command 1). In the grant cycle `shared_in` is sampled, the line becomes shared-clean if it is high and exclusive-clean if it is low, and `cpu_done` pulses.
- R3: A write to an absent line first requests a bus read. If `shared_in` is low at that grant, the line becomes dirty and `cpu_done` and `local_wr` pulse in that cycle. If it is high, the line becomes shared-clean and a word update (bus command 2) is requested next.
- R4: A write to an exclusive-clean or dirty line completes in its cycle with `cpu_done` and `local_wr` and no bus request, and leaves the line dirty.
- R5: A write to a shared-clean or shared-owner line requests a word update. `local_wr` is given only in the grant cycle. The line then becomes shared-owner if `shared_in` is high and dirty if it is low.
- R6: A read of a present line completes in its cycle with no bus request and no state change.
- R7: A snooped bus read (snoop command 1) on a present line drives `shared_out`. On a dirty or shared-owner line it also drives `flush`. Dirty becomes shared-owner, exclusive-clean becomes shared-clean, and the other states are kept.
- R8: A snooped word update (snoop command 2) on a present line drives `shared_out` and `snp_apply`, and turns shared-owner into shared-clean. Snoops on absent lines and snoop commands 0 and 3 have no effect.
- R9: Eviction (cpu_op 2 or 3) of a dirty or shared-owner line requests a write-back (bus command 3), and the line becomes absent at the grant. Eviction of a clean line makes it absent in its cycle with no bus request. Eviction of an absent line just completes.
- R10: While idle, a processor operation whose index equals the index of a valid snoop in the same cycle is held back: no done, no write strobe and no request in that cycle.
- R11: A bus request holds its command and index stable until it is granted. cpu_op encodes 0 as read, 1 as write and 2 or 3 as evict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor operation present, held until done |
| cpu_op | input | 2 | 0 read, 1 write, 2 or 3 evict |
| cpu_idx | input | IDX_W | Line index of the processor operation |
| cpu_done | output | 1 | Operation finished this cycle |
| local_wr | output | 1 | Write the processor word into the local copy now |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 1 read, 2 word update, 3 write-back, 0 when idle |
| bus_idx | output | IDX_W | Line index of the requested transaction |
| bus_gnt | input | 1 | Own transaction is on the bus this cycle |
| shared_in | input | 1 | Wired-OR shared line seen during own transaction |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| shared_out | output | 1 | Drive the shared line: snooped line is present here |
| flush | output | 1 | Supply this cache's dirty line for the snooped read |
| snp_apply | output | 1 | Write the snooped word into the local copy |

## Verification
The bench builds the block with LINES=4, so two-bit indices make random processor and snoop traffic land on the same lines often. Every state pair between this cache and its peers is then reached within a few thousand cycles, and same-index collisions between an idle request and a snoop happen often enough to exercise the hold-back rule. Grants come after varied delays while snoops arrive in between, so the states reached during a pending update, write-back or two-phase write miss are covered as well.

// File: rtl/upd_coh_pkg.sv
package upd_coh_pkg;

   typedef enum logic [2:0] {
      LN_ABSENT  = 3'd0,
      LN_EXCL    = 3'd1,
      LN_SHCLEAN = 3'd2,
      LN_SHOWNER = 3'd3,
      LN_DIRTY   = 3'd4
   } line_st_t;

   typedef enum logic [1:0] {
      BC_NONE    = 2'd0,
      BC_READ    = 2'd1,
      BC_UPDATE  = 2'd2,
      BC_WRBACK  = 2'd3
   } bus_cmd_t;

   localparam logic [1:0] OP_READ  = 2'd0;
   localparam logic [1:0] OP_WRITE = 2'd1;

   function automatic logic is_present(input line_st_t s);
      return s != LN_ABSENT;
   endfunction

   function automatic logic is_owner(input line_st_t s);
      return (s == LN_SHOWNER) || (s == LN_DIRTY);
   endfunction

endpackage

// File: rtl/upd_coh_lines.sv
module upd_coh_lines
   import upd_coh_pkg::*;
#(
   parameter int LINES = 8,
   parameter int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] cpu_idx,
   input  logic             cpu_we,
   input  line_st_t         cpu_new,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             snp_we,
   input  line_st_t         snp_new,
   output line_st_t         cpu_st,
   output line_st_t         snp_st
);

   line_st_t st_vec [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
      line_st_t st_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r <= LN_ABSENT;
         end else if (snp_we && (snp_idx == MY_IDX)) begin
            st_r <= snp_new;
         end else if (cpu_we && (cpu_idx == MY_IDX)) begin
            st_r <= cpu_new;
         end
      end

      assign st_vec[g] = st_r;
   end

   assign cpu_st = st_vec[cpu_idx];
   assign snp_st = st_vec[snp_idx];

endmodule

// File: rtl/upd_coh_snoop.sv
module upd_coh_snoop
   import upd_coh_pkg::*;
(
   input  logic     snp_valid,
   input  bus_cmd_t snp_cmd,
   input  line_st_t snp_st,
   output logic     shared_out,
   output logic     flush,
   output logic     snp_apply,
   output logic     snp_we,
   output line_st_t snp_new
);

   logic seen_rd;
   logic seen_upd;
   logic here;

   assign here     = is_present(snp_st);
   assign seen_rd  = snp_valid && (snp_cmd == BC_READ);
   assign seen_upd = snp_valid && (snp_cmd == BC_UPDATE);

   // R7, R8: answer only for lines that are held here
   assign shared_out = (seen_rd || seen_upd) && here;
   assign flush      = seen_rd && is_owner(snp_st);
   assign snp_apply  = seen_upd && here;
   assign snp_we     = shared_out;

   always_comb begin
      snp_new = snp_st;
      if (seen_rd) begin
         unique case (snp_st)
            LN_EXCL:  snp_new = LN_SHCLEAN;
            LN_DIRTY: snp_new = LN_SHOWNER;
            default:  snp_new = snp_st;
         endcase
      end else if (seen_upd) begin
         if (snp_st == LN_SHOWNER) snp_new = LN_SHCLEAN;
      end
   end

endmodule

// File: rtl/upd_coh_seq.sv
module upd_coh_seq
   import upd_coh_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic [1:0]       cpu_op,
   input  logic [IDX_W-1:0] cpu_idx,
   input  line_st_t         cur_st,
   input  logic             snp_valid,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             bus_gnt,
   input  logic             shared_in,
   output logic [IDX_W-1:0] look_idx,
   output logic             cpu_done,
   output logic             local_wr,
   output logic             bus_req,
   output bus_cmd_t         bus_cmd,
   output logic [IDX_W-1:0] bus_idx,
   output logic             cpu_we,
   output line_st_t         cpu_new
);

   logic             busy_q, busy_d;
   bus_cmd_t         cmd_q, cmd_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             wmiss_q, wmiss_d;
   logic             collide;
   logic             is_evict;

   assign look_idx = busy_q ? idx_q : cpu_idx;
   assign collide  = snp_valid && (snp_idx == cpu_idx);   // R10
   assign is_evict = cpu_op[1];

   assign bus_req = busy_q;
   assign bus_cmd = busy_q ? cmd_q : BC_NONE;
   assign bus_idx = idx_q;

   always_comb begin
      busy_d   = busy_q;
      cmd_d    = cmd_q;
      idx_d    = idx_q;
      wmiss_d  = wmiss_q;
      cpu_done = 1'b0;
      local_wr = 1'b0;
      cpu_we   = 1'b0;
      cpu_new  = cur_st;

      if (!busy_q) begin
         if (cpu_valid && !collide) begin
            idx_d = cpu_idx;
            if (is_evict) begin
               // R9
               if (is_owner(cur_st)) begin
                  busy_d  = 1'b1;
                  cmd_d   = BC_WRBACK;
                  wmiss_d = 1'b0;
               end else begin
                  cpu_done = 1'b1;
                  cpu_we   = is_present(cur_st);
                  cpu_new  = LN_ABSENT;
               end
            end else if (cpu_op == OP_WRITE) begin
               unique case (cur_st)
                  LN_EXCL, LN_DIRTY: begin          // R4
                     cpu_done = 1'b1;
                     local_wr = 1'b1;
                     cpu_we   = 1'b1;
                     cpu_new  = LN_DIRTY;
                  end
                  LN_SHCLEAN, LN_SHOWNER: begin     // R5
                     busy_d  = 1'b1;
                     cmd_d   = BC_UPDATE;
                     wmiss_d = 1'b0;
                  end
                  default: begin                    // R3
                     busy_d  = 1'b1;
                     cmd_d   = BC_READ;
                     wmiss_d = 1'b1;
                  end
               endcase
            end else begin
               if (is_present(cur_st)) begin        // R6
                  cpu_done = 1'b1;
               end else begin                       // R2
                  busy_d  = 1'b1;
                  cmd_d   = BC_READ;
                  wmiss_d = 1'b0;
               end
            end
         end
      end else if (bus_gnt) begin
         cpu_we = 1'b1;
         unique case (cmd_q)
            BC_READ: begin
               if (!wmiss_q) begin
                  cpu_new  = shared_in ? LN_SHCLEAN : LN_EXCL;
                  cpu_done = 1'b1;
                  busy_d   = 1'b0;
               end else if (shared_in) begin
                  cpu_new = LN_SHCLEAN;
                  cmd_d   = BC_UPDATE;
                  wmiss_d = 1'b0;
               end else begin
                  cpu_new  = LN_DIRTY;
                  cpu_done = 1'b1;
                  local_wr = 1'b1;
                  busy_d   = 1'b0;
               end
            end
            BC_UPDATE: begin
               cpu_new  = shared_in ? LN_SHOWNER : LN_DIRTY;
               cpu_done = 1'b1;
               local_wr = 1'b1;
               busy_d   = 1'b0;
            end
            BC_WRBACK: begin
               cpu_new  = LN_ABSENT;
               cpu_done = 1'b1;
               busy_d   = 1'b0;
            end
            default: begin
               cpu_we = 1'b0;
               busy_d = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cmd_q   <= BC_NONE;
         idx_q   <= '0;
         wmiss_q <= 1'b0;
      end else begin
         busy_q  <= busy_d;
         cmd_q   <= cmd_d;
         idx_q   <= idx_d;
         wmiss_q <= wmiss_d;
      end
   end

endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
   import upd_coh_pkg::*;
#(
   parameter int LINES = 8,
   localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_valid,
   input  logic [1:0]       cpu_op,
   input  logic [IDX_W-1:0] cpu_idx,
   output logic             cpu_done,
   output logic             local_wr,
   output logic             bus_req,
   output logic [1:0]       bus_cmd,
   output logic [IDX_W-1:0] bus_idx,
   input  logic             bus_gnt,
   input  logic             shared_in,
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [IDX_W-1:0] snp_idx,
   output logic             shared_out,
   output logic             flush,
   output logic             snp_apply
);

   if (LINES < 2) begin : g_bad_lines
      $error("upd_coh_ctrl: LINES must be at least 2");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_pow2
      $error("upd_coh_ctrl: LINES must be a power of two");
   end

   logic [IDX_W-1:0] look_idx;
   line_st_t         cur_st, snp_st, cpu_new, snp_new;
   logic             cpu_we, snp_we;
   bus_cmd_t         cmd_o;
   bus_cmd_t         snp_cmd_t;

   assign snp_cmd_t = bus_cmd_t'(snp_cmd);
   assign bus_cmd   = cmd_o;

   upd_coh_lines #(.LINES(LINES), .IDX_W(IDX_W)) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .cpu_idx (look_idx),
      .cpu_we  (cpu_we),
      .cpu_new (cpu_new),
      .snp_idx (snp_idx),
      .snp_we  (snp_we),
      .snp_new (snp_new),
      .cpu_st  (cur_st),
      .snp_st  (snp_st)
   );

   upd_coh_snoop u_snoop (
      .snp_valid  (snp_valid),
      .snp_cmd    (snp_cmd_t),
      .snp_st     (snp_st),
      .shared_out (shared_out),
      .flush      (flush),
      .snp_apply  (snp_apply),
      .snp_we     (snp_we),
      .snp_new    (snp_new)
   );

   upd_coh_seq #(.IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_valid (cpu_valid),
      .cpu_op    (cpu_op),
      .cpu_idx   (cpu_idx),
      .cur_st    (cur_st),
      .snp_valid (snp_valid),
      .snp_idx   (snp_idx),
      .bus_gnt   (bus_gnt),
      .shared_in (shared_in),
      .look_idx  (look_idx),
      .cpu_done  (cpu_done),
      .local_wr  (local_wr),
      .bus_req   (bus_req),
      .bus_cmd   (cmd_o),
      .bus_idx   (bus_idx),
      .cpu_we    (cpu_we),
      .cpu_new   (cpu_new)
   );

endmodule

// File: rtl/upd_coh_chk.sv
module upd_coh_chk #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_valid,
   input logic [1:0]       cpu_op,
   input logic [IDX_W-1:0] cpu_idx,
   input logic             cpu_done,
   input logic             local_wr,
   input logic             bus_req,
   input logic [1:0]       bus_cmd,
   input logic [IDX_W-1:0] bus_idx,
   input logic             bus_gnt,
   input logic             snp_valid,
   input logic [1:0]       snp_cmd,
   input logic [IDX_W-1:0] snp_idx,
   input logic             shared_out,
   input logic             flush,
   input logic             snp_apply
);

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_idx)));

   assert_flush_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (snp_valid && snp_cmd == 2'd1 && shared_out));

   assert_apply_on_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
      snp_apply |-> (snp_valid && snp_cmd == 2'd2 && shared_out));

   assert_shared_needs_snoop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      shared_out |-> snp_valid);

   assert_write_after_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (local_wr && bus_req) |-> bus_gnt);

   assert_write_is_cpu_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      local_wr |-> (cpu_valid && cpu_op == 2'd1 && cpu_done));

   assert_no_collide_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && !bus_req) |-> !(snp_valid && snp_idx == cpu_idx));

   assert_done_ends_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_done && bus_req) |=> !bus_req);

endmodule

bind upd_coh_ctrl upd_coh_chk #(.IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_valid  (cpu_valid),
   .cpu_op     (cpu_op),
   .cpu_idx    (cpu_idx),
   .cpu_done   (cpu_done),
   .local_wr   (local_wr),
   .bus_req    (bus_req),
   .bus_cmd    (bus_cmd),
   .bus_idx    (bus_idx),
   .bus_gnt    (bus_gnt),
   .snp_valid  (snp_valid),
   .snp_cmd    (snp_cmd),
   .snp_idx    (snp_idx),
   .shared_out (shared_out),
   .flush      (flush),
   .snp_apply  (snp_apply)
);

// File: tb/test_upd_coh_ctrl.sv
`timescale 1ns/1ps
module test_upd_coh_ctrl;

   localparam int LINES = 4;
   localparam int IW    = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_valid;
   logic [1:0]    cpu_op;
   logic [IW-1:0] cpu_idx;
   logic          cpu_done, local_wr, bus_req;
   logic [1:0]    bus_cmd;
   logic [IW-1:0] bus_idx;
   logic          bus_gnt, shared_in, snp_valid;
   logic [1:0]    snp_cmd;
   logic [IW-1:0] snp_idx;
   logic          shared_out, flush, snp_apply;

   always #2.5 clk = ~clk;

   upd_coh_ctrl #(.LINES(LINES)) i_upd_coh_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_op(cpu_op),
      .cpu_idx(cpu_idx), .cpu_done(cpu_done), .local_wr(local_wr),
      .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
      .bus_gnt(bus_gnt), .shared_in(shared_in), .snp_valid(snp_valid),
      .snp_cmd(snp_cmd), .snp_idx(snp_idx), .shared_out(shared_out),
      .flush(flush), .snp_apply(snp_apply)
   );

   int nchk = 0;
   int nerr = 0;
   bit fin  = 0;
   int unsigned seed = 32'h1d2b_4c57;

   // reference state: 0 absent, 1 excl-clean, 2 shared-clean, 3 shared-owner, 4 dirty
   int m_line [LINES];
   bit m_busy;
   int m_cmd, m_idx;
   bit m_wm;

   task automatic rnd(output int unsigned v);
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      v = seed;
   endtask

   task automatic chk(input int act, input int exp, input string rq, input string what);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!fin) begin
         nerr++;
         $display("FAIL R11 watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      bit prev_done;
      rst_n = 1'b0; cpu_valid = 1'b0; cpu_op = '0; cpu_idx = '0;
      bus_gnt = 1'b0; shared_in = 1'b0; snp_valid = 1'b0; snp_cmd = '0; snp_idx = '0;
      for (int i = 0; i < LINES; i++) m_line[i] = 0;
      m_busy = 0; m_cmd = 0; m_idx = 0; m_wm = 0;
      prev_done = 0;
      repeat (3) @(negedge clk);
      // R1: outputs quiet under reset
      chk(bus_req, 0, "R1", "bus_req in reset");
      chk(cpu_done, 0, "R1", "cpu_done in reset");
      chk(local_wr, 0, "R1", "local_wr in reset");
      chk(shared_out | flush | snp_apply, 0, "R1", "snoop outputs in reset");
      rst_n = 1'b1;

      for (int cyc = 0; cyc < 4000; cyc++) begin
         int unsigned r;
         int st, cst, cidx, snst, sidx;
         bit e_done, e_lwr, e_sh, e_fl, e_ap, cwe, swe, sh;
         bit n_busy, n_wm;
         int n_cmd, n_idx;
         string tag_c, tag_s;

         // drive inputs
         if (!cpu_valid || prev_done) begin
            rnd(r);
            if (cyc == 0) begin
               cpu_valid = 1'b1; cpu_op = 2'd0; cpu_idx = '0;   // R1 first read
            end else if (r % 4 != 0) begin
               cpu_valid = 1'b1;
               cpu_op  = ((r >> 4) % 8 < 3) ? 2'd0 : (((r >> 4) % 8 < 6) ? 2'd1 : 2'(2 + (r >> 8) % 2));
               cpu_idx = IW'((r >> 12) % LINES);
            end else begin
               cpu_valid = 1'b0;
            end
         end
         rnd(r);
         bus_gnt   = m_busy && (r % 3 == 0);
         snp_valid = !bus_gnt && ((r >> 3) % 3 == 0) && (cyc > 0);
         snp_cmd   = 2'((r >> 6) % 4);
         snp_idx   = IW'((r >> 9) % LINES);
         shared_in = (r >> 12) % 2;
         #1;

         // reference model, evaluated on the settled inputs
         sh = shared_in;
         sidx = snp_idx;
         snst = m_line[sidx];
         e_sh = snp_valid && (snp_cmd == 1 || snp_cmd == 2) && snst != 0;
         e_fl = snp_valid && snp_cmd == 1 && (snst == 3 || snst == 4);
         e_ap = snp_valid && snp_cmd == 2 && snst != 0;
         swe = e_sh;
         if (snp_cmd == 1) begin
            if (snst == 1) snst = 2;
            else if (snst == 4) snst = 3;
         end else if (snp_cmd == 2 && snst == 3) snst = 2;
         tag_s = (snp_cmd == 2) ? "R8" : "R7";

         e_done = 0; e_lwr = 0; cwe = 0; cst = 0; cidx = 0;
         n_busy = m_busy; n_cmd = m_cmd; n_idx = m_idx; n_wm = m_wm;
         tag_c = "R11";
         if (!m_busy) begin
            if (cpu_valid && snp_valid && snp_idx == cpu_idx) begin
               tag_c = "R10";
            end else if (cpu_valid) begin
               cidx = cpu_idx;
               st = m_line[cidx];
               if (cpu_op >= 2) begin
                  tag_c = "R9";
                  if (st == 3 || st == 4) begin
                     n_busy = 1; n_cmd = 3; n_idx = cidx; n_wm = 0;
                  end else begin
                     e_done = 1; cwe = (st != 0); cst = 0;
                  end
               end else if (cpu_op == 1) begin
                  if (st == 1 || st == 4) begin
                     tag_c = "R4"; e_done = 1; e_lwr = 1; cwe = 1; cst = 4;
                  end else if (st == 2 || st == 3) begin
                     tag_c = "R5"; n_busy = 1; n_cmd = 2; n_idx = cidx; n_wm = 0;
                  end else begin
                     tag_c = "R3"; n_busy = 1; n_cmd = 1; n_idx = cidx; n_wm = 1;
                  end
               end else begin
                  if (st != 0) begin
                     tag_c = "R6"; e_done = 1;
                  end else begin
                     tag_c = (cyc == 0) ? "R1" : "R2";
                     n_busy = 1; n_cmd = 1; n_idx = cidx; n_wm = 0;
                  end
               end
            end
         end else if (bus_gnt) begin
            cidx = m_idx; cwe = 1;
            if (m_cmd == 1 && !m_wm) begin
               tag_c = "R2"; cst = sh ? 2 : 1; e_done = 1; n_busy = 0;
            end else if (m_cmd == 1) begin
               tag_c = "R3";
               if (sh) begin
                  cst = 2; n_cmd = 2; n_wm = 0;
               end else begin
                  cst = 4; e_done = 1; e_lwr = 1; n_busy = 0;
               end
            end else if (m_cmd == 2) begin
               tag_c = "R5"; cst = sh ? 3 : 4; e_done = 1; e_lwr = 1; n_busy = 0;
            end else begin
               tag_c = "R9"; cst = 0; e_done = 1; n_busy = 0;
            end
         end

         chk(cpu_done, e_done, tag_c, "cpu_done");
         chk(local_wr, e_lwr, tag_c, "local_wr");
         chk(bus_req, m_busy, tag_c, "bus_req");
         chk(bus_cmd, m_busy ? m_cmd : 0, "R11", "bus_cmd");
         if (m_busy) chk(bus_idx, m_idx, "R11", "bus_idx");
         chk(shared_out, e_sh, tag_s, "shared_out");
         chk(flush, e_fl, "R7", "flush");
         chk(snp_apply, e_ap, "R8", "snp_apply");

         @(posedge clk);
         if (swe) m_line[sidx] = snst;
         if (cwe) m_line[cidx] = cst;
         m_busy = n_busy; m_cmd = n_cmd; m_idx = n_idx; m_wm = n_wm;
         prev_done = e_done;
         @(negedge clk);
      end

      fin = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule